// File: doc/BRIEF.md
# DMA Channel Event Latch with Completion Chaining

This block is the request front end of a multi-channel DMA controller. Each channel has a hardware event input. A one-cycle pulse on that input is held in a pending register until the channel is dispatched. An enable register decides which pending channels may be dispatched. Software reaches all of this through a small register port. Two write-one registers let software drop pending requests or raise them by hand.

Each cycle the block looks at the pending bits that are also enabled and takes the lowest-numbered one. It raises a one-cycle trigger to the transfer engine, carrying that channel number, and clears the pending bit at the same clock edge. When the engine later reports a finished transfer with chaining turned on, the block sets the pending bit of the channel named in the completion code. One finished channel can therefore start another channel. Chaining only raises a request and changes no transfer configuration.

Top module: `dma_evt_front`

## Requirements
- R1: A one-cycle high on `evt_in[n]` sets pending bit n at the next rising clock edge.
- R2: A pending channel whose enable bit is 0 is never dispatched. Its pending bit stays set.
- R3: A write to address 2 clears every pending bit whose write-data bit is 1. Zero data bits have no effect.
- R4: A write to address 3 sets every pending bit whose write-data bit is 1. Zero data bits have no effect.
- R5: When `cmp_valid` and `cmp_chain` are both high, the pending bit numbered `cmp_code` is set at the next edge. When `cmp_chain` is low, the completion report has no effect.
- R6: While any pending bit with its enable bit set exists, `trig_valid` is high and `trig_chan` gives the lowest such channel number. That channel's pending bit is cleared at the next edge.
- R7: An event, a set write or a chain hit on a bit wins over a clear write or a dispatch clear of the same bit in the same cycle. The bit ends up set.
- R8: Reset clears the pending and enable registers, so `trig_valid` is low.
- R9: Register map:
  - Address 0 reads the pending register.
  - Address 1 reads and writes the enable register.
  - Addresses 2 and 3 are write-only and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NCH | Per-channel event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NCH | Register write data |
| bus_rdata | output | NCH | Register read data, combinational on `bus_addr` |
| cmp_valid | input | 1 | Transfer completion report from the engine |
| cmp_chain | input | 1 | Chaining enabled for the reported completion |
| cmp_code | input | CW | Completion code, the channel to chain to |
| trig_valid | output | 1 | One-cycle dispatch trigger to the engine |
| trig_chan | output | CW | Channel number being dispatched |

## Verification
Event pulses, set and clear writes, and chain reports all land in the pending register at the first rising edge after they are driven. A read one cycle later therefore shows their effect. The dispatch trigger is combinational from the pending and enable registers. It is visible in the same cycle that the pending bit becomes set or that the enable write takes effect. Pending bits are cleared one edge later.

The bench drives inputs and samples outputs on falling edges. Before each stimulus, the driver queues every channel expected to dispatch, in expected order. A falling-edge monitor pops one entry per trigger cycle, so a missing, extra or reordered dispatch is caught in the cycle it happens.

// File: rtl/evl_pkg.sv
package evl_pkg;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_EN   = 2'd1,
    RA_CLR  = 2'd2,
    RA_SET  = 2'd3
  } evl_reg_e;
endpackage

// File: rtl/evl_regs.sv
module evl_regs
  import evl_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] en,
  output logic [NCH-1:0] sw_clr,
  output logic [NCH-1:0] sw_set,
  output logic [NCH-1:0] bus_rdata
);
  evl_reg_e ra;
  assign ra = evl_reg_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (bus_wr && ra == RA_EN) en <= bus_wdata;
  end

  assign sw_clr = (bus_wr && ra == RA_CLR) ? bus_wdata : '0;
  assign sw_set = (bus_wr && ra == RA_SET) ? bus_wdata : '0;

  always_comb begin
    case (ra)
      RA_PEND: bus_rdata = pend;
      RA_EN:   bus_rdata = en;
      default: bus_rdata = '0;
    endcase
  end

  // R9: enable register holds the written value
  a_r9_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ra == RA_EN) |=> en == $past(bus_wdata));
endmodule

// File: rtl/evl_pend.sv
module evl_pend #(
  parameter int NCH = 64,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_in,
  input  logic [NCH-1:0] sw_set,
  input  logic [NCH-1:0] sw_clr,
  input  logic           cmp_valid,
  input  logic           cmp_chain,
  input  logic [CW-1:0]  cmp_code,
  input  logic [NCH-1:0] disp_clr,
  output logic [NCH-1:0] set_all,
  output logic [NCH-1:0] pend
);
  function automatic logic [NCH-1:0] code_to_bit(input logic [CW-1:0] c);
    return {{(NCH-1){1'b0}}, 1'b1} << c;
  endfunction

  logic [NCH-1:0] chain_set;
  logic [NCH-1:0] clr_all;

  assign chain_set = (cmp_valid && cmp_chain) ? code_to_bit(cmp_code) : '0;
  assign set_all   = evt_in | sw_set | chain_set;
  assign clr_all   = sw_clr | disp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_all) | set_all;
  end

  // R1 R4 R5 R7: every set source lands, whatever the clears do
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ($past(set_all) & ~pend) == '0);
  // R3: a clear with no competing set empties the bit
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_clr) |=> (pend & $past(sw_clr & ~set_all)) == '0);
  // R5: chain target is pending after the report
  a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_chain) |=> pend[$past(cmp_code)]);
endmodule

// File: rtl/evl_pick.sv
module evl_pick #(
  parameter int NCH = 64,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant,
  output logic           any,
  output logic [CW-1:0]  idx
);
  function automatic logic [CW-1:0] bit_to_code(input logic [NCH-1:0] oh);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NCH; i++)
      if (oh[i]) c = c | CW'(i);
    return c;
  endfunction

  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NCH];
  assign idx = bit_to_code(grant);

  // R6: at most one channel granted
  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/dma_evt_front.sv
module dma_evt_front #(
  parameter int NCH = 64,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_in,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  output logic [NCH-1:0] bus_rdata,
  input  logic           cmp_valid,
  input  logic           cmp_chain,
  input  logic [CW-1:0]  cmp_code,
  output logic           trig_valid,
  output logic [CW-1:0]  trig_chan
);
  function automatic logic [NCH-1:0] below_mask(input logic [CW-1:0] c);
    return ({{(NCH-1){1'b0}}, 1'b1} << c) - 1'b1;
  endfunction

  logic [NCH-1:0] pend, en, sw_clr, sw_set, set_all, ready, grant;

  evl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(pend), .en(en), .sw_clr(sw_clr),
    .sw_set(sw_set), .bus_rdata(bus_rdata)
  );

  evl_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sw_set(sw_set),
    .sw_clr(sw_clr), .cmp_valid(cmp_valid), .cmp_chain(cmp_chain),
    .cmp_code(cmp_code), .disp_clr(grant), .set_all(set_all), .pend(pend)
  );

  assign ready = pend & en;

  evl_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(ready), .grant(grant),
    .any(trig_valid), .idx(trig_chan)
  );

  // R2: only enabled pending channels are dispatched
  a_r2_trig_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (en[trig_chan] && pend[trig_chan]));
  // R6: nothing enabled and pending below the dispatched channel
  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (pend & en & below_mask(trig_chan)) == '0);
  // R6: dispatched channel is cleared unless a set source re-raises it
  a_r6_disp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !set_all[trig_chan]) |=> !pend[$past(trig_chan)]);
  // R8: no trigger without any pending bit
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !trig_valid);
endmodule

// File: tb/sim_dma_evt_front.sv
module sim_dma_evt_front;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int CW = 6;
  localparam logic [NCH-1:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] evt_in = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, cmp_valid = 0, cmp_chain = 0, trig_valid;
  logic [1:0] bus_addr = 0;
  logic [CW-1:0] cmp_code = '0, trig_chan;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_evt_front #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_valid(cmp_valid), .cmp_chain(cmp_chain), .cmp_code(cmp_code),
    .trig_valid(trig_valid), .trig_chan(trig_chan)
  );

  function automatic logic [NCH-1:0] b(input int n);
    return {{(NCH-1){1'b0}}, 1'b1} << n;
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NCH-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NCH-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic complete(input logic chain, input int code);
    @(negedge clk); cmp_valid = 1; cmp_chain = chain; cmp_code = CW'(code);
    @(negedge clk); cmp_valid = 0; cmp_chain = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: one scoreboard entry per trigger cycle (R6)
  always @(negedge clk) begin
    if (rst_n && trig_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected trigger actual=%0d expected=none", trig_chan);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(trig_chan) != e) begin
          n_fail++;
          $display("FAIL R6 trigger order actual=%0d expected=%0d", trig_chan, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NCH-1:0] d;
    idle(3); rst_n = 1; idle(1);
    // R8 reset state
    rd(0, d); check("R8 pending", d, '0);
    rd(1, d); check("R8 enable", d, '0);
    check("R8 trig_valid", {63'b0, trig_valid}, '0);
    // R1 / R2
    pulse(b(5) | b(40));
    rd(0, d); check("R1 event latch", d, b(5) | b(40));
    idle(3);
    rd(0, d); check("R2 disabled stays pending", d, b(5) | b(40));
    // R3
    wr(2, '0); rd(0, d); check("R3 zero clear", d, b(5) | b(40));
    wr(2, b(5)); rd(0, d); check("R3 clear bit", d, b(40));
    // R4
    wr(3, '0); rd(0, d); check("R4 zero set", d, b(40));
    wr(3, b(7)); rd(0, d); check("R4 set bit", d, b(7) | b(40));
    // R9
    rd(2, d); check("R9 clear reads zero", d, '0);
    rd(3, d); check("R9 set reads zero", d, '0);
    // R6 dispatch order
    exp_q.push_back(7); exp_q.push_back(40);
    wr(1, ONES);
    rd(1, d); check("R9 enable readback", d, ONES);
    idle(4);
    check("R6 queue drained", NCH'(exp_q.size()), '0);
    rd(0, d); check("R6 pending cleared", d, '0);
    // R7 set sources beat clear write
    wr(1, '0);
    @(negedge clk); evt_in = b(3); bus_wr = 1; bus_addr = 2; bus_wdata = b(3);
    @(negedge clk); evt_in = '0; bus_wr = 0; bus_wdata = '0;
    rd(0, d); check("R7 event beats clear", d, b(3));
    @(negedge clk); cmp_valid = 1; cmp_chain = 1; cmp_code = 9;
    bus_wr = 1; bus_addr = 2; bus_wdata = b(9);
    @(negedge clk); cmp_valid = 0; cmp_chain = 0; bus_wr = 0; bus_wdata = '0;
    rd(0, d); check("R7 chain beats clear", d, b(3) | b(9));
    wr(2, ONES); rd(0, d); check("R3 clear all", d, '0);
    // R5
    complete(0, 12); rd(0, d); check("R5 no chain no effect", d, '0);
    complete(1, 12); rd(0, d); check("R5 chain sets target", d, b(12));
    wr(2, ONES);
    exp_q.push_back(20);
    wr(1, b(20) | b(21));
    wr(3, b(20));
    exp_q.push_back(21);
    complete(1, 21);
    idle(2);
    rd(0, d); check("R5 chained channel dispatched", d, '0);
    // R6 priority among simultaneous events
    wr(1, ONES);
    exp_q.push_back(0); exp_q.push_back(31); exp_q.push_back(63);
    pulse(b(0) | b(31) | b(63));
    idle(4);
    check("R6 priority drained", NCH'(exp_q.size()), '0);
    // R7 event beats dispatch clear
    exp_q.push_back(2); exp_q.push_back(2); exp_q.push_back(2);
    @(negedge clk); evt_in = b(2);
    idle(3); evt_in = '0;
    idle(2);
    rd(0, d); check("R7 held event retriggers", d, '0);
    check("R7 queue drained", NCH'(exp_q.size()), '0);
    finish_run();
  end
endmodule